// File: doc/BRIEF.md
# Jittered Switching Clock Generator

This block derives the switching-cycle timing of a cycle-skipping power controller from a fast system clock. It produces a one-clock pulse at the start of every switching cycle and a maximum-duty window. The window opens with that pulse and bounds how long the power switch may stay on within the cycle. The average cycle rate is about 132 kHz.

To spread emission energy, the cycle length is swept along a slow triangle whenever `jitter_en` is high. The length moves by a fixed step once per cycle. It starts from the centre value and heads toward the long-period limit, then turns back at each limit. The limits lie about 4.5 kHz either side of the centre frequency. The step is chosen so that one full triangle lasts roughly one period of a 1.5 kHz modulation. With `jitter_en` low, every cycle uses the centre length.

All frequencies and the duty fraction are parameters. Cycle lengths are whole numbers of system clocks.

Top module: `jitclk_gen`

## Requirements
- R1: While `rst` is high, `cyc_start` and `duty_win` are 0. After reset the first cycle has the centre length and the sweep direction is toward longer periods.
- R2: `cyc_start` is high for exactly one clock per switching cycle. The distance between consecutive pulses is the length of that cycle.
- R3: A cycle whose closing boundary sees `jitter_en` low is followed by a cycle of the centre length. The sweep direction returns to "longer".
- R4: With `jitter_en` high, each cycle is longer or shorter than the previous one by STEP clocks. STEP = max(1, (PER_MAX-PER_MIN)*2*MOD_HZ/CENTER_HZ), computed with integer division.
- R5: The sweep turns around at PER_MAX and PER_MIN. If a step would reach or pass a limit, the next cycle is clamped to that limit and the direction flips. No cycle length lies outside [PER_MIN, PER_MAX].
- R6: `duty_win` rises only together with `cyc_start`. It stays high for floor(L*DUTY_PCT/100) clocks of a cycle of length L, then stays low until the next pulse.
- R7: `jitter_en` is sampled only on the last clock of a cycle. Changes earlier in the cycle affect neither the current nor the next cycle length.
- R8: The centre length is SYS_CLK_HZ/CENTER_HZ. PER_MIN is SYS_CLK_HZ/(CENTER_HZ+JITTER_PP_HZ/2) and PER_MAX is SYS_CLK_HZ/(CENTER_HZ-JITTER_PP_HZ/2), all with integer division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| jitter_en | input | 1 | Enables the triangular period sweep |
| cyc_start | output | 1 | One-clock pulse marking the first clock of a switching cycle |
| duty_win | output | 1 | High while switch-on is permitted within the cycle |

## Verification
The checker watches the port-level shape on every clock:
- the start pulse is one clock wide;
- the window opens only with a pulse and is closed before the next one;
- every measured cycle length stays inside the limits.

What the checker cannot see is which length a given cycle should have. That covers the exact sweep sequence, its reversals at both limits, the return to centre when the sweep is disabled, the insensitivity to mid-cycle enable changes, the restart from centre after a mid-sweep reset, and the exact window length for each period. Only the bench scenarios, compared against an independent model, show these.

// File: rtl/jitclk_pkg.sv
package jitclk_pkg;
  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/jitclk_sweep.sv
module jitclk_sweep
  import jitclk_pkg::*;
#(
  parameter int PW      = 10,
  parameter int PER_CTR = 757,
  parameter int PER_MIN = 732,
  parameter int PER_MAX = 784,
  parameter int STEP    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          en,
  output logic [PW-1:0] per_q,
  output logic [PW-1:0] per_nxt
);
  localparam logic [PW:0] MIN_W  = (PW+1)'(PER_MIN);
  localparam logic [PW:0] MAX_W  = (PW+1)'(PER_MAX);
  localparam logic [PW:0] STEP_W = (PW+1)'(STEP);

  sweep_dir_e dir_q, dir_nxt;

  generate
    if (PER_MAX <= PER_MIN) begin : g_flat
      // no spread: the length never moves
      always_comb begin
        per_nxt = PW'(PER_CTR);
        dir_nxt = SWEEP_UP;
      end
    end else begin : g_tri
      always_comb begin
        per_nxt = PW'(PER_CTR);
        dir_nxt = SWEEP_UP;
        if (en) begin
          if (dir_q == SWEEP_UP) begin
            if (({1'b0, per_q} + STEP_W) >= MAX_W) begin
              per_nxt = PW'(PER_MAX);
              dir_nxt = SWEEP_DOWN;
            end else begin
              per_nxt = per_q + STEP_W[PW-1:0];
              dir_nxt = SWEEP_UP;
            end
          end else begin
            if ({1'b0, per_q} <= (MIN_W + STEP_W)) begin
              per_nxt = PW'(PER_MIN);
              dir_nxt = SWEEP_UP;
            end else begin
              per_nxt = per_q - STEP_W[PW-1:0];
              dir_nxt = SWEEP_DOWN;
            end
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= PW'(PER_CTR);
      dir_q <= SWEEP_UP;
    end else if (adv) begin
      per_q <= per_nxt;
      dir_q <= dir_nxt;
    end
  end
endmodule

// File: rtl/jitclk_duty.sv
module jitclk_duty #(
  parameter int PW       = 10,
  parameter int PER_CTR  = 757,
  parameter int DUTY_PCT = 65
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [PW-1:0] per_nxt,
  output logic [PW-1:0] duty_q
);
  localparam int PRODW = PW + 8;
  localparam logic [PW-1:0] DUTY_RST =
    (DUTY_PCT >= 100) ? PW'(PER_CTR) : PW'((PER_CTR * DUTY_PCT) / 100);

  logic [PW-1:0] duty_nxt;

  generate
    if (DUTY_PCT >= 100) begin : g_full
      assign duty_nxt = per_nxt;
    end else begin : g_frac
      logic [PRODW-1:0] prod;
      logic [PRODW-1:0] quot;
      assign prod     = PRODW'(per_nxt) * PRODW'(DUTY_PCT);
      assign quot     = prod / PRODW'(100);
      assign duty_nxt = quot[PW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= DUTY_RST;
    end else if (adv) begin
      duty_q <= duty_nxt;
    end
  end
endmodule

// File: rtl/jitclk_cycle.sv
module jitclk_cycle #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] per,
  input  logic [PW-1:0] duty,
  output logic          wrap,
  output logic          start_o,
  output logic          win_o
);
  logic [PW-1:0] cnt_q;

  assign wrap = (cnt_q == (per - PW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_o <= 1'b0;
      win_o   <= 1'b0;
    end else begin
      cnt_q   <= wrap ? '0 : cnt_q + PW'(1);
      start_o <= (cnt_q == '0);
      win_o   <= (cnt_q < duty);
    end
  end
endmodule

// File: rtl/jitclk_gen.sv
module jitclk_gen #(
  parameter int SYS_CLK_HZ   = 100_000_000,
  parameter int CENTER_HZ    = 132_000,
  parameter int JITTER_PP_HZ = 9_000,
  parameter int MOD_HZ       = 1_500,
  parameter int DUTY_PCT     = 65
) (
  input  logic clk,
  input  logic rst,
  input  logic jitter_en,
  output logic cyc_start,
  output logic duty_win
);
  localparam int PER_CTR  = SYS_CLK_HZ / CENTER_HZ;
  localparam int PER_MIN  = SYS_CLK_HZ / (CENTER_HZ + JITTER_PP_HZ / 2);
  localparam int PER_MAX  = SYS_CLK_HZ / (CENTER_HZ - JITTER_PP_HZ / 2);
  localparam int STEP_RAW = ((PER_MAX - PER_MIN) * 2 * MOD_HZ) / CENTER_HZ;
  localparam int STEP     = (STEP_RAW < 1) ? 1 : STEP_RAW;
  localparam int PW       = $clog2(PER_MAX + 1);

  logic          wrap;
  logic [PW-1:0] per_q;
  logic [PW-1:0] per_nxt;
  logic [PW-1:0] duty_q;

  jitclk_sweep #(
    .PW(PW), .PER_CTR(PER_CTR), .PER_MIN(PER_MIN),
    .PER_MAX(PER_MAX), .STEP(STEP)
  ) u_sweep (
    .clk(clk), .rst(rst), .adv(wrap), .en(jitter_en),
    .per_q(per_q), .per_nxt(per_nxt)
  );

  jitclk_duty #(
    .PW(PW), .PER_CTR(PER_CTR), .DUTY_PCT(DUTY_PCT)
  ) u_duty (
    .clk(clk), .rst(rst), .adv(wrap), .per_nxt(per_nxt), .duty_q(duty_q)
  );

  jitclk_cycle #(
    .PW(PW)
  ) u_cycle (
    .clk(clk), .rst(rst), .per(per_q), .duty(duty_q),
    .wrap(wrap), .start_o(cyc_start), .win_o(duty_win)
  );
endmodule

// File: rtl/jitclk_gen_chk.sv
module jitclk_gen_chk #(
  parameter int PER_MIN = 732,
  parameter int PER_MAX = 784
) (
  input logic clk,
  input logic rst,
  input logic cyc_start,
  input logic duty_win
);
  localparam int CW = $clog2(PER_MAX + 2);
  localparam logic [CW-1:0] GAP_TOP = {CW{1'b1}};

  logic [CW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (cyc_start) begin
      gap_q  <= CW'(1);
      seen_q <= 1'b1;
    end else if (gap_q != GAP_TOP) begin
      gap_q <= gap_q + CW'(1);
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start); // R2

  AST_WIN_WITH_START: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> duty_win); // R6

  AST_WIN_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(duty_win) |-> cyc_start); // R6

  AST_WIN_CLOSED_BEFORE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && seen_q) |-> !$past(duty_win)); // R6

  AST_GAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && seen_q) |-> (gap_q >= CW'(PER_MIN) && gap_q <= CW'(PER_MAX))); // R5
endmodule

bind jitclk_gen jitclk_gen_chk #(
  .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
) u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .duty_win(duty_win)
);

// File: tb/sim_jitclk_gen.sv
module sim_jitclk_gen;
  // 6.6 MHz system rate: R8 gives centre 50, PER_MIN 48, PER_MAX 51, STEP 1
  localparam int EXP_CTR = 50;
  localparam int EXP_MIN = 48;
  localparam int EXP_MAX = 51;
  localparam int EXP_STEP = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic jitter_en = 1'b0;
  logic cyc_start;
  logic duty_win;

  always #5 clk = ~clk;

  jitclk_gen #(
    .SYS_CLK_HZ(6_600_000), .CENTER_HZ(132_000), .JITTER_PP_HZ(9_000),
    .MOD_HZ(1_500), .DUTY_PCT(65)
  ) u0 (
    .clk(clk), .rst(rst), .jitter_en(jitter_en),
    .cyc_start(cyc_start), .duty_win(duty_win)
  );

  typedef struct {
    int    per;
    int    duty;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  int m_per   = EXP_CTR;
  bit m_up    = 1'b1;
  bit done    = 1'b0;

  task automatic check(string req, string what, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int duty_of(int p);
    return (p * 65) / 100;
  endfunction

  task automatic model_step(bit en);
    if (!en) begin
      m_per = EXP_CTR;
      m_up  = 1'b1;
    end else if (m_up) begin
      if (m_per + EXP_STEP >= EXP_MAX) begin m_per = EXP_MAX; m_up = 1'b0; end
      else m_per = m_per + EXP_STEP;
    end else begin
      if (m_per <= EXP_MIN + EXP_STEP) begin m_per = EXP_MIN; m_up = 1'b1; end
      else m_per = m_per - EXP_STEP;
    end
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!cyc_start);
  endtask

  task automatic push_cur(string tag);
    exp_t e;
    e.per  = m_per;
    e.duty = duty_of(m_per);
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // driver: one call per switching cycle
  task automatic drive_cycles(int n, bit en, string base);
    for (int i = 0; i < n; i++) begin
      wait_start();
      if (m_per == EXP_MAX || m_per == EXP_MIN) push_cur("R5");
      else push_cur(base);
      jitter_en = en;
      model_step(en);
    end
  endtask

  // R7: enable dropped mid-cycle, restored before the boundary
  task automatic drive_glitch();
    wait_start();
    push_cur("R7");
    jitter_en = 1'b0;
    repeat (10) @(negedge clk);
    jitter_en = 1'b1;
    model_step(1'b1);
  endtask

  task automatic do_reset();
    wait_start();
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "cyc_start in reset", int'(cyc_start), 0);
    check("R1", "duty_win in reset", int'(duty_win), 0);
    exp_q.delete();
    m_per = EXP_CTR;
    m_up  = 1'b1;
    jitter_en = 1'b1;
    rst = 1'b0;
  endtask

  // monitor: measures each cycle and compares with the queue head
  initial begin
    int  len = 0;
    int  hi  = 0;
    bit  active = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst) begin
        active = 1'b0;
        len = 0;
        hi  = 0;
      end else begin
        if (cyc_start) begin
          if (active) begin
            check("R2", "pulse spacing above one", int'(len > 1), 1);
            if (exp_q.size() == 0) begin
              check("R2", "unexpected cycle", 1, 0);
            end else begin
              e = exp_q.pop_front();
              check(e.tag, "cycle length", len, e.per);
              check("R6", "window length", hi, e.duty);
            end
          end
          check("R6", "window open at start", int'(duty_win), 1);
          active = 1'b1;
          len = 0;
          hi  = 0;
        end
        len++;
        if (duty_win) hi++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "cyc_start in reset", int'(cyc_start), 0);
    check("R1", "duty_win in reset", int'(duty_win), 0);
    rst = 1'b0;
    // first cycle: centre length (R1, R8), then upward sweep with reversals
    wait_start();
    push_cur("R1 R8");
    jitter_en = 1'b1;
    model_step(1'b1);
    drive_cycles(13, 1'b1, "R4");
    drive_cycles(4, 1'b0, "R3");
    drive_cycles(3, 1'b1, "R4");
    drive_glitch();
    drive_cycles(3, 1'b1, "R4");
    do_reset();
    wait_start();
    push_cur("R1");
    model_step(1'b1);
    drive_cycles(5, 1'b1, "R4");
    wait_start();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule